// File: doc/BRIEF.md
# MSI Capture and Interrupt Aggregator

This block sits on the host side of a PCI Express root port. It turns inbound message-signalled interrupt writes into status bits and folds them, together with the four legacy level-style interrupt lines, into one upstream interrupt wire. The block holds a number of vector groups (8 by default), and each group has 32 vectors. Each group owns a 64-bit match address, a 32-bit pending register and a 32-bit vector-mask register. An inbound write whose address equals a group's match address marks one vector of that group pending. The write data selects the vector.

A second level of status collects one summary bit per group plus one bit per legacy line. A top-level mask register decides which of these bits reach the interrupt wire. Software reaches every register over a simple single-cycle register bus. Read data is returned one cycle after the read strobe. Inbound writes come in on a valid/ready port. The block never applies back-pressure: `msi_ready` is always high, and a write is taken in every cycle in which `msi_valid` is high. Packet decoding happens upstream of this block. Legacy interrupt assert and de-assert messages come in as single-cycle event strobes.

Top module: `msi_irq_aggregator`

## Requirements
- R1: After reset, every register reads 0, `irq_out` is low and `msi_ready` is high.
- R2: Register map (byte offsets on `reg_addr`):
  - Group n match-address low word: 0xC00+0x10·n.
  - Group n pending register: 0xC04+0x10·n.
  - Group n vector mask: 0xC08+0x10·n.
  - Group n match-address high word: 0xC80+4·n.
  - Top mask: 0x180.
  - Top status: 0x184.
  - Group capture-enable register: 0x190, bit n for group n.
  - Writable fields read back what was written. Top-mask bits outside 8..15 and 24..27 read 0. Capture-enable bits above the group count read 0.
- R3: A write accepted on the inbound port sets pending bit `msi_data[4:0]` of every group whose capture-enable bit is 1 and whose {high,low} match address equals `msi_addr`.
- R4: Writing 1 to a pending bit clears it and writing 0 leaves it unchanged. A capture of the same bit in the same cycle wins, so the bit stays set.
- R5: An inbound write is ignored, leaving all pending bits unchanged, in two cases:
  - its address matches no group whose capture-enable bit is set;
  - its data is 32 or more.
- R6: Top status bit 8+n is set in the cycle after group n has a bit that is both pending and unmasked. It stays set until a 1 is written to it. That write only clears it when the group has no pending unmasked bit.
- R7: A legacy assert message on line k (0..3) sets top status bit 24+k. Writing 1 to that bit has no effect while the line is asserted. After the de-assert message arrives, the bit stays set until a 1 is written to it.
- R8: `irq_out` is high exactly when some top status bit and the same top mask bit are both 1.
- R9: A pending bit whose vector-mask bit is 0 does not set the group's summary bit. Once the mask bit is set, the summary bit follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| msi_valid | input | 1 | Inbound interrupt write valid |
| msi_ready | output | 1 | Always 1; inbound writes are never stalled |
| msi_addr | input | 64 | Inbound write address |
| msi_data | input | 32 | Inbound write data (vector index) |
| intx_valid | input | 1 | Legacy interrupt message strobe |
| intx_line | input | 2 | Legacy line index, 0..3 |
| intx_assert | input | 1 | 1 = assert message, 0 = de-assert message |
| irq_out | output | 1 | Upstream interrupt |

## Verification
The assertions assume the following about the inputs:
- Each group's match address is programmed distinct before any inbound write is sent to it.
- A de-assert message and a write-1 clear of the same legacy bit never arrive in the same cycle.
- The pending-register clear checks only apply in cycles that carry no capture to that group.

The directed stimulus follows these rules. It programs unique addresses for all groups first and drives one event per cycle, except in the one scenario that deliberately puts a capture and a clear of the same bit in the same cycle. Every outcome is read back through the register bus or observed on `irq_out`, never by looking inside the block.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
  localparam int unsigned RB_AW    = 12;
  localparam int unsigned RB_DW    = 32;
  localparam int unsigned SUM_LSB  = 8;
  localparam int unsigned INTX_LSB = 24;
  localparam int unsigned NUM_INTX = 4;

  localparam logic [RB_AW-1:0] OFS_TOP_MASK = 12'h180;
  localparam logic [RB_AW-1:0] OFS_TOP_STS  = 12'h184;
  localparam logic [RB_AW-1:0] OFS_CAP_EN   = 12'h190;
  localparam logic [RB_AW-1:0] OFS_GRP_BASE = 12'hC00;
  localparam logic [RB_AW-1:0] OFS_HI_BASE  = 12'hC80;

  function automatic logic [RB_AW-1:0] grp_lo_ofs(input int unsigned n);
    return OFS_GRP_BASE + RB_AW'(n * 16);
  endfunction

  function automatic logic [RB_AW-1:0] grp_pend_ofs(input int unsigned n);
    return OFS_GRP_BASE + RB_AW'(n * 16 + 4);
  endfunction

  function automatic logic [RB_AW-1:0] grp_mask_ofs(input int unsigned n);
    return OFS_GRP_BASE + RB_AW'(n * 16 + 8);
  endfunction

  function automatic logic [RB_AW-1:0] grp_hi_ofs(input int unsigned n);
    return OFS_HI_BASE + RB_AW'(n * 4);
  endfunction
endpackage

// File: rtl/msi_vec_group.sv
module msi_vec_group #(
  parameter int unsigned VEC = 32,
  parameter int unsigned DW  = 32,
  localparam int unsigned VW  = $clog2(VEC),
  localparam int unsigned MAW = 2 * DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_lo,
  input  logic           wr_hi,
  input  logic           wr_pend,
  input  logic           wr_mask,
  input  logic [DW-1:0]  wdata,
  input  logic           cap_on,
  input  logic           msi_fire,
  input  logic [MAW-1:0] msi_addr,
  input  logic [VW-1:0]  msi_vec,
  output logic [DW-1:0]  match_lo,
  output logic [DW-1:0]  match_hi,
  output logic [VEC-1:0] pend,
  output logic [VEC-1:0] vmask,
  output logic           hit,
  output logic           active
);
  logic [VEC-1:0] set_bits, clr_bits;

  assign hit      = msi_fire && cap_on && (msi_addr == {match_hi, match_lo});
  assign set_bits = hit ? ({{(VEC-1){1'b0}}, 1'b1} << msi_vec) : '0;
  assign clr_bits = wr_pend ? wdata[VEC-1:0] : '0;
  assign active   = |(pend & vmask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_lo <= '0;
      match_hi <= '0;
      pend     <= '0;
      vmask    <= '0;
    end else begin
      if (wr_lo)   match_lo <= wdata;
      if (wr_hi)   match_hi <= wdata;
      if (wr_mask) vmask    <= wdata[VEC-1:0];
      pend <= (pend & ~clr_bits) | set_bits;
    end
  end

  // R3 / R4: a capture always lands, even against a simultaneous clear
  a_r3_capture_lands: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pend[$past(msi_vec)]);

  // R4: a write-1 clear without capture leaves the written bits at zero
  a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && !hit) |=> ((pend & $past(wdata[VEC-1:0])) == '0));
endmodule

// File: rtl/intx_level_track.sv
module intx_level_track #(
  parameter int unsigned N = 4,
  localparam int unsigned LW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          msg_valid,
  input  logic [LW-1:0] msg_line,
  input  logic          msg_assert,
  input  logic [N-1:0]  clr,
  output logic [N-1:0]  sts
);
  logic [N-1:0] line_q;

  for (genvar k = 0; k < N; k++) begin : g_line
    logic sel;
    assign sel = msg_valid && (msg_line == LW'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        line_q[k] <= 1'b0;
        sts[k]    <= 1'b0;
      end else begin
        if (sel) line_q[k] <= msg_assert;
        sts[k] <= (sel && msg_assert) || (sts[k] && !(clr[k] && !line_q[k]));
      end
    end
  end

  // R7: status of an asserted line cannot be cleared
  a_r7_hold_while_asserted: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts & line_q) != '0) |=> (($past(sts & line_q) & ~sts) == '0));
endmodule

// File: rtl/msi_irq_aggregator.sv
module msi_irq_aggregator
  import msi_agg_pkg::*;
#(
  parameter int unsigned NUM_SETS    = 8,
  parameter int unsigned VEC_PER_SET = 32,
  localparam int unsigned VW  = $clog2(VEC_PER_SET),
  localparam int unsigned MAW = 2 * RB_DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [RB_AW-1:0] reg_addr,
  input  logic [RB_DW-1:0] reg_wdata,
  output logic [RB_DW-1:0] reg_rdata,
  input  logic             msi_valid,
  output logic             msi_ready,
  input  logic [MAW-1:0]   msi_addr,
  input  logic [RB_DW-1:0] msi_data,
  input  logic             intx_valid,
  input  logic [1:0]       intx_line,
  input  logic             intx_assert,
  output logic             irq_out
);
  localparam logic [RB_DW-1:0] TOP_MASK_BITS =
    (RB_DW'((1 << NUM_SETS) - 1) << SUM_LSB) | (RB_DW'((1 << NUM_INTX) - 1) << INTX_LSB);

  logic [RB_DW-1:0]       top_mask_q, top_sts, rd_mux;
  logic [NUM_SETS-1:0]    cap_en_q, sum_q, grp_active, grp_hit;
  logic [NUM_INTX-1:0]    intx_sts, intx_clr;
  logic                   top_w1c, msi_fire;
  logic [RB_DW-1:0]       rb_lo [NUM_SETS];
  logic [RB_DW-1:0]       rb_hi [NUM_SETS];
  logic [VEC_PER_SET-1:0] rb_pend [NUM_SETS];
  logic [VEC_PER_SET-1:0] rb_vmask [NUM_SETS];
  logic [NUM_SETS*VEC_PER_SET-1:0] pend_flat;

  assign msi_ready = 1'b1;
  assign msi_fire  = msi_valid && (msi_data[RB_DW-1:VW] == '0);
  assign top_w1c   = reg_wr && (reg_addr == OFS_TOP_STS);
  assign intx_clr  = top_w1c ? reg_wdata[INTX_LSB +: NUM_INTX] : '0;

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_grp
    msi_vec_group #(.VEC(VEC_PER_SET), .DW(RB_DW)) u_grp (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_lo    (reg_wr && (reg_addr == grp_lo_ofs(g))),
      .wr_hi    (reg_wr && (reg_addr == grp_hi_ofs(g))),
      .wr_pend  (reg_wr && (reg_addr == grp_pend_ofs(g))),
      .wr_mask  (reg_wr && (reg_addr == grp_mask_ofs(g))),
      .wdata    (reg_wdata),
      .cap_on   (cap_en_q[g]),
      .msi_fire (msi_fire),
      .msi_addr (msi_addr),
      .msi_vec  (msi_data[VW-1:0]),
      .match_lo (rb_lo[g]),
      .match_hi (rb_hi[g]),
      .pend     (rb_pend[g]),
      .vmask    (rb_vmask[g]),
      .hit      (grp_hit[g]),
      .active   (grp_active[g])
    );
    assign pend_flat[g*VEC_PER_SET +: VEC_PER_SET] = rb_pend[g];
  end

  intx_level_track #(.N(NUM_INTX)) u_intx (
    .clk        (clk),
    .rst_n      (rst_n),
    .msg_valid  (intx_valid),
    .msg_line   (intx_line),
    .msg_assert (intx_assert),
    .clr        (intx_clr),
    .sts        (intx_sts)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_mask_q <= '0;
      cap_en_q   <= '0;
      sum_q      <= '0;
      reg_rdata  <= '0;
    end else begin
      if (reg_wr && reg_addr == OFS_TOP_MASK) top_mask_q <= reg_wdata & TOP_MASK_BITS;
      if (reg_wr && reg_addr == OFS_CAP_EN)   cap_en_q   <= reg_wdata[NUM_SETS-1:0];
      sum_q <= grp_active | (sum_q & ~(top_w1c ? reg_wdata[SUM_LSB +: NUM_SETS] : '0));
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end

  always_comb begin
    top_sts = '0;
    top_sts[SUM_LSB +: NUM_SETS]  = sum_q;
    top_sts[INTX_LSB +: NUM_INTX] = intx_sts;
  end

  assign irq_out = |(top_sts & top_mask_q);

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      OFS_TOP_MASK: rd_mux = top_mask_q;
      OFS_TOP_STS:  rd_mux = top_sts;
      OFS_CAP_EN:   rd_mux = RB_DW'(cap_en_q);
      default: ;
    endcase
    for (int i = 0; i < NUM_SETS; i++) begin
      if (reg_addr == grp_lo_ofs(i))   rd_mux = rb_lo[i];
      if (reg_addr == grp_hi_ofs(i))   rd_mux = rb_hi[i];
      if (reg_addr == grp_pend_ofs(i)) rd_mux = RB_DW'(rb_pend[i]);
      if (reg_addr == grp_mask_ofs(i)) rd_mux = RB_DW'(rb_vmask[i]);
    end
  end

  // R6: an active group raises its summary bit on the next edge
  a_r6_summary_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_active != '0) |=> (($past(grp_active) & ~sum_q) == '0));

  // R5: an unmatched inbound write with no register write changes no pending bit
  a_r5_unmatched_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && (grp_hit == '0) && !reg_wr) |=> $stable(pend_flat));

  // R8: nothing reaches the interrupt wire while the top mask is clear
  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (top_mask_q == '0) |-> !irq_out);
endmodule

// File: tb/msi_irq_aggregator_bench.sv
module msi_irq_aggregator_bench;
  localparam logic [11:0] A_TOP_MASK = 12'h180;
  localparam logic [11:0] A_TOP_STS  = 12'h184;
  localparam logic [11:0] A_CAP_EN   = 12'h190;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        msi_valid = 1'b0, msi_ready;
  logic [63:0] msi_addr = '0;
  logic [31:0] msi_data = '0;
  logic        intx_valid = 1'b0, intx_assert = 1'b0;
  logic [1:0]  intx_line = '0;
  logic        irq_out;
  int checks = 0, failures = 0;

  always #5ns clk = ~clk;

  msi_irq_aggregator u_msi_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msi_valid(msi_valid),
    .msi_ready(msi_ready), .msi_addr(msi_addr), .msi_data(msi_data),
    .intx_valid(intx_valid), .intx_line(intx_line), .intx_assert(intx_assert),
    .irq_out(irq_out)
  );

  function automatic logic [11:0] a_lo(input int n);   return 12'hC00 + 12'(n*16);     endfunction
  function automatic logic [11:0] a_pend(input int n); return 12'hC04 + 12'(n*16);     endfunction
  function automatic logic [11:0] a_mask(input int n); return 12'hC08 + 12'(n*16);     endfunction
  function automatic logic [11:0] a_hi(input int n);   return 12'hC80 + 12'(n*4);      endfunction
  function automatic logic [31:0] v_lo(input int n);   return 32'h8000_0C00 + 32'(n*256); endfunction
  function automatic logic [31:0] v_hi(input int n);   return 32'h0000_0010 + 32'(n);  endfunction
  function automatic logic [63:0] tgt(input int n);    return {v_hi(n), v_lo(n)};      endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic send_msi(input logic [63:0] a, input logic [31:0] d);
    @(negedge clk); msi_valid = 1'b1; msi_addr = a; msi_data = d;
    @(negedge clk); msi_valid = 1'b0;
  endtask

  task automatic send_intx(input int line, input logic asrt);
    @(negedge clk); intx_valid = 1'b1; intx_line = 2'(line); intx_assert = asrt;
    @(negedge clk); intx_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_TOP_STS, v);  chk("R1 top status after reset", v, 0);
    rd(a_pend(0), v);  chk("R1 pending after reset", v, 0);
    rd(a_lo(5), v);    chk("R1 match address after reset", v, 0);
    chk("R1 irq low after reset", 32'(irq_out), 0);
    chk("R1 ready high", 32'(msi_ready), 1);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    for (int n = 0; n < 8; n++) begin
      wr(a_lo(n), v_lo(n));
      wr(a_hi(n), v_hi(n));
    end
    wr(A_CAP_EN, 32'hFFFF_FFFF);
    wr(a_mask(2), 32'hFFFF_FFFF);
    wr(A_TOP_MASK, 32'hFFFF_FFFF);
    rd(a_lo(3), v);     chk("R2 low word group 3", v, v_lo(3));
    rd(a_hi(7), v);     chk("R2 high word group 7", v, v_hi(7));
    rd(a_mask(2), v);   chk("R2 vector mask group 2", v, 32'hFFFF_FFFF);
    rd(A_CAP_EN, v);    chk("R2 capture enable width", v, 32'h0000_00FF);
    rd(A_TOP_MASK, v);  chk("R2 top mask unused bits", v, 32'h0F00_FF00);
  endtask

  task automatic t_capture();
    logic [31:0] v;
    send_msi(tgt(2), 5);
    @(negedge clk);
    rd(a_pend(2), v);  chk("R3 capture vector 5 group 2", v, 32'h20);
    rd(A_TOP_STS, v);  chk("R6 summary bit group 2", v, 32'h400);
    chk("R8 irq high", 32'(irq_out), 1);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(a_pend(2), 0);
    rd(a_pend(2), v);  chk("R4 write zero keeps bit", v, 32'h20);
    wr(A_TOP_STS, 32'h400);
    rd(A_TOP_STS, v);  chk("R6 summary held while active", v, 32'h400);
    wr(a_pend(2), 32'h20);
    rd(a_pend(2), v);  chk("R4 write one clears", v, 0);
    rd(A_TOP_STS, v);  chk("R6 summary sticky after source clear", v, 32'h400);
    wr(A_TOP_STS, 32'h400);
    rd(A_TOP_STS, v);  chk("R6 summary cleared", v, 0);
    chk("R8 irq low after clear", 32'(irq_out), 0);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    @(negedge clk);
    msi_valid = 1'b1; msi_addr = tgt(2); msi_data = 9;
    reg_wr = 1'b1; reg_addr = a_pend(2); reg_wdata = 32'h200;
    @(negedge clk); msi_valid = 1'b0; reg_wr = 1'b0;
    rd(a_pend(2), v);  chk("R4 capture beats same-cycle clear", v, 32'h200);
    wr(a_pend(2), 32'h200);
    wr(A_TOP_STS, 32'h400);
    rd(A_TOP_STS, v);  chk("R4 cleanup", v, 0);
  endtask

  task automatic t_ignore();
    logic [31:0] v;
    send_msi(tgt(2) + 64'h4, 1);
    send_msi(tgt(2), 32);
    wr(A_CAP_EN, 32'h0000_00EF);
    wr(a_mask(4), 32'hFFFF_FFFF);
    send_msi(tgt(4), 0);
    @(negedge clk);
    rd(a_pend(2), v);  chk("R5 unmatched or wide data ignored", v, 0);
    rd(a_pend(4), v);  chk("R5 disabled group ignored", v, 0);
    rd(A_TOP_STS, v);  chk("R5 no summary", v, 0);
    chk("R5 irq stays low", 32'(irq_out), 0);
    wr(A_CAP_EN, 32'h0000_00FF);
  endtask

  task automatic t_vmask();
    logic [31:0] v;
    send_msi(tgt(1), 3);
    @(negedge clk);
    rd(a_pend(1), v);  chk("R3 capture while masked", v, 32'h8);
    rd(A_TOP_STS, v);  chk("R9 masked vector gives no summary", v, 0);
    wr(a_mask(1), 32'h8);
    @(negedge clk);
    rd(A_TOP_STS, v);  chk("R9 unmask raises summary", v, 32'h200);
    wr(a_pend(1), 32'h8);
    wr(A_TOP_STS, 32'h200);
    rd(A_TOP_STS, v);  chk("R9 cleanup", v, 0);
  endtask

  task automatic t_intx();
    logic [31:0] v;
    send_intx(2, 1'b1);
    rd(A_TOP_STS, v);  chk("R7 INTC sets bit 26", v, 32'h0400_0000);
    chk("R8 irq from legacy line", 32'(irq_out), 1);
    wr(A_TOP_STS, 32'h0400_0000);
    rd(A_TOP_STS, v);  chk("R7 clear ignored while asserted", v, 32'h0400_0000);
    wr(A_TOP_MASK, 0);
    chk("R8 mask blocks irq", 32'(irq_out), 0);
    wr(A_TOP_MASK, 32'h0F00_FF00);
    chk("R8 unmask restores irq", 32'(irq_out), 1);
    send_intx(2, 1'b0);
    rd(A_TOP_STS, v);  chk("R7 stays set after de-assert", v, 32'h0400_0000);
    wr(A_TOP_STS, 32'h0400_0000);
    rd(A_TOP_STS, v);  chk("R7 clear after de-assert", v, 0);
    send_intx(0, 1'b1);
    rd(A_TOP_STS, v);  chk("R7 INTA sets bit 24", v, 32'h0100_0000);
    send_intx(0, 1'b0);
    wr(A_TOP_STS, 32'h0100_0000);
    rd(A_TOP_STS, v);  chk("R7 INTA cleared", v, 0);
    chk("R8 irq low at end", 32'(irq_out), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_capture();
    t_clear();
    t_collision();
    t_ignore();
    t_vmask();
    t_intx();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule